// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block widens the addresses of outbound memory requests. A request arrives with a local address. The bits above the page offset pick one entry of a translation table. The output address is that entry's stored base with the page offset carried over unchanged. All entries share one power-of-two page size of 2^PAGE_BITS bytes. The number of index bits is SPACE_BITS - PAGE_BITS, where 2^SPACE_BITS bytes is the total remote space the block can reach. Each entry also holds a 2-bit attribute code, which is sent out with the translated request.

A register port writes and reads the table. Each entry has a low word and a high word. When the wide-addressing mode input is set, the request's 64-bit address is forwarded without translation. The translation sits behind one output register with a valid/ready handshake on both sides.

Top module: `addr_xlat`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every table word reads back as 0.
- R2: In narrow mode (wide_mode=0), out_addr bits [PAGE_BITS-1:0] equal the request's in_addr bits [PAGE_BITS-1:0].
- R3: In narrow mode, the entry used is in_addr[SPACE_BITS-1:PAGE_BITS]. out_addr bits [31:PAGE_BITS] equal that entry's low-word base bits. in_addr bits at and above SPACE_BITS have no effect on the result.
- R4: In narrow mode, if bit 0 of the entry's attribute is 1, out_addr[63:32] equals the entry's high word. If that bit is 0, out_addr[63:32] is 0.
- R5: In narrow mode, out_attr equals the attribute code stored in the selected entry.
- R6: When wide_mode is 1 at acceptance, out_addr equals in_addr on all 64 bits and out_attr is 0.
- R7: cfg_sel bit 0 picks the word: 0 is the low word, 1 is the high word. cfg_sel[IDX_W:1] picks the entry. A low-word write stores bits [31:PAGE_BITS] as the base and bits [1:0] as the attribute, and discards bits [PAGE_BITS-1:2]. The low word reads back as base | attribute. The high word reads back as written. cfg_rdata follows cfg_sel within the same cycle.
- R8: A table write takes effect for requests accepted on the next cycle or later. A request accepted on the same clock edge as the write uses the old contents.
- R9: A request accepted on a clock edge appears at the output after that edge. While out_valid=1 and out_ready=0, out_valid, out_addr and out_attr hold their values.
- R10: in_ready is 1 exactly when the output register is empty or out_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 forwards the address untranslated |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 64 | Request address (bits [31:0] are used in narrow mode) |
| out_valid | output | 1 | Translated request present |
| out_ready | input | 1 | Downstream accepts the request |
| out_addr | output | 64 | Translated address |
| out_attr | output | 2 | Attribute code of the selected entry |
| cfg_wr | input | 1 | Table write strobe |
| cfg_sel | input | IDX_W+1 | Entry and word select |
| cfg_wdata | input | 32 | Table write data |
| cfg_rdata | output | 32 | Table read data |

## Verification
Every table entry is exercised with three page offsets: zero, all ones, and a mixed value. The mixed-value requests also set the local bits above SPACE_BITS, so errors in offset merging show up separately from errors in entry selection. Entries with attribute bit 0 set and clear show whether the upper half is copied from the high word or zeroed. Wide-mode requests with arbitrary 64-bit values check that the table is bypassed. A stretch of pseudo-random backpressure checks that the output holds and that results keep their order. One request arrives in the same cycle as a rewrite of its own entry, and the next request to that entry follows it; this pair tells apart the old contents from the new.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int WORD_W = 32;
    localparam int ATTR_W = 2;

    typedef struct packed {
        logic [63:0]       addr;
        logic [ATTR_W-1:0] attr;
    } xlat_req_t;

    // Mask covering the page-offset bits.
    function automatic logic [63:0] offset_mask(input int unsigned page_bits);
        return (64'd1 << page_bits) - 64'd1;
    endfunction

endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [IDX_W:0]    cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [63:0]       lk_base,
    output logic [ATTR_W-1:0] lk_attr
);
    localparam int               ENTRIES  = 1 << IDX_W;
    localparam logic [63:0]      OFS_MASK = offset_mask(PAGE_BITS);
    localparam logic [WORD_W-1:0] BASE_KEEP = ~OFS_MASK[WORD_W-1:0];

    logic [WORD_W-1:0] lo_q   [ENTRIES];
    logic [WORD_W-1:0] hi_q   [ENTRIES];
    logic [ATTR_W-1:0] attr_q [ENTRIES];

    logic [IDX_W-1:0] cfg_ent;
    assign cfg_ent = cfg_sel[IDX_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                attr_q[i] <= '0;
            end
        end else if (cfg_wr) begin
            if (cfg_sel[0]) begin
                hi_q[cfg_ent] <= cfg_wdata;
            end else begin
                lo_q[cfg_ent]   <= cfg_wdata & BASE_KEEP;
                attr_q[cfg_ent] <= cfg_wdata[ATTR_W-1:0];
            end
        end
    end

    always_comb begin
        if (cfg_sel[0])
            cfg_rdata = hi_q[cfg_ent];
        else
            cfg_rdata = lo_q[cfg_ent] | {{(WORD_W-ATTR_W){1'b0}}, attr_q[cfg_ent]};
    end

    assign lk_base = {hi_q[lk_idx], lo_q[lk_idx]};
    assign lk_attr = attr_q[lk_idx];

endmodule

// File: rtl/xlat_compose.sv
module xlat_compose
    import xlat_pkg::*;
#(
    parameter int PAGE_BITS  = 12,
    parameter int SPACE_BITS = 16
) (
    input  logic                            wide,
    input  logic [63:0]                     in_addr,
    output logic [SPACE_BITS-PAGE_BITS-1:0] idx,
    input  logic [63:0]                     base,
    input  logic [ATTR_W-1:0]               attr,
    output xlat_req_t                       result
);
    localparam logic [63:0] OFS_MASK = offset_mask(PAGE_BITS);

    logic [63:0] merged;

    assign idx = in_addr[SPACE_BITS-1:PAGE_BITS];

    always_comb begin
        merged = (base & ~OFS_MASK) | (in_addr & OFS_MASK);
        if (!attr[0])
            merged[63:32] = '0;
        if (wide) begin
            result.addr = in_addr;
            result.attr = '0;
        end else begin
            result.addr = merged;
            result.attr = attr;
        end
    end

endmodule

// File: rtl/xlat_stage.sv
module xlat_stage
    import xlat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output logic      in_ready,
    input  xlat_req_t d,
    output logic      out_valid,
    input  logic      out_ready,
    output xlat_req_t q
);
    logic full_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            q      <= '0;
        end else if (in_ready) begin
            full_q <= in_valid;
            if (in_valid)
                q <= d;
        end
    end

endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
    import xlat_pkg::*;
#(
    parameter int PAGE_BITS  = 12,
    parameter int SPACE_BITS = 16,
    localparam int IDX_W     = SPACE_BITS - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_addr,
    output logic [1:0]        out_attr,
    input  logic              cfg_wr,
    input  logic [IDX_W:0]    cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    logic [IDX_W-1:0]  lk_idx;
    logic [63:0]       lk_base;
    logic [ATTR_W-1:0] lk_attr;
    xlat_req_t         next_req;
    xlat_req_t         held_req;

    xlat_table #(.PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_idx(lk_idx), .lk_base(lk_base), .lk_attr(lk_attr)
    );

    xlat_compose #(.PAGE_BITS(PAGE_BITS), .SPACE_BITS(SPACE_BITS)) u_compose (
        .wide(wide_mode), .in_addr(in_addr), .idx(lk_idx),
        .base(lk_base), .attr(lk_attr), .result(next_req)
    );

    xlat_stage u_stage (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .d(next_req),
        .out_valid(out_valid), .out_ready(out_ready), .q(held_req)
    );

    assign out_addr = held_req.addr;
    assign out_attr = held_req.attr;

endmodule

// File: rtl/addr_xlat_check.sv
module addr_xlat_check #(
    parameter int PAGE_BITS = 12
) (
    input logic        clk,
    input logic        rst,
    input logic        wide_mode,
    input logic        in_valid,
    input logic        in_ready,
    input logic [63:0] in_addr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_addr,
    input logic [1:0]  out_attr
);
    localparam logic [63:0] LOW = (64'd1 << PAGE_BITS) - 64'd1;

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_attr))); // R9

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_WIDE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && wide_mode) |=> (out_addr == $past(in_addr) && out_attr == 2'b00)); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !wide_mode) |=> ((out_addr & LOW) == ($past(in_addr) & LOW))); // R2

endmodule

bind addr_xlat addr_xlat_check #(.PAGE_BITS(PAGE_BITS)) u_check (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_attr(out_attr)
);

// File: tb/addr_xlat_bench.sv
module addr_xlat_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PB  = 12;
    localparam int SB  = 16;
    localparam int IW  = SB - PB;
    localparam int NE  = 1 << IW;
    localparam logic [63:0] LOWM = (64'd1 << PB) - 64'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_addr;
    logic [1:0]  out_attr;
    logic        cfg_wr = 1'b0;
    logic [IW:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_lo [NE];
    logic [31:0] m_hi [NE];
    logic [1:0]  m_at [NE];

    logic [65:0] exp_q [$];
    string       tag_q [$];

    logic       rdy_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_xlat #(.PAGE_BITS(PB), .SPACE_BITS(SB)) u_addr_xlat (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_attr(out_attr), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = rdy_mode ? (lfsr[0] | lfsr[3]) : 1'b1;

    task automatic check(input bit ok, input string req, input logic [65:0] got, input logic [65:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [65:0] model(input logic [63:0] a, input logic w);
        logic [IW-1:0] ix;
        logic [63:0]   r;
        if (w) return {2'b00, a};
        ix = a[SB-1:PB];
        r = ({m_hi[ix], m_lo[ix]} & ~LOWM) | (a & LOWM);
        if (!m_at[ix][0]) r[63:32] = '0;
        return {m_at[ix], r};
    endfunction

    task automatic cfg_write(input int ent, input bit hi, input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = {ent[IW-1:0], hi}; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (hi) m_hi[ent] = v;
        else begin m_lo[ent] = v & ~LOWM[31:0]; m_at[ent] = v[1:0]; end
    endtask

    task automatic cfg_check(input int ent, input bit hi, input string req);
        logic [31:0] e;
        @(negedge clk);
        cfg_sel = {ent[IW-1:0], hi};
        #1;
        e = hi ? m_hi[ent] : (m_lo[ent] | {30'b0, m_at[ent]});
        check(cfg_rdata == e, req, {34'b0, cfg_rdata}, {34'b0, e});
    endtask

    task automatic send(input logic [63:0] a, input logic w, input string req);
        bit acc;
        exp_q.push_back(model(a, w));
        tag_q.push_back(req);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; wide_mode = w;
        forever begin
            #1 acc = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    // Monitor: compares transfers, output hold under stall, and ready rule.
    initial begin
        bit          hold_p = 0;
        logic [65:0] hold_v = '0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (hold_p)
                    check(out_valid && {out_attr, out_addr} == hold_v, "R9 hold",
                          {out_attr, out_addr}, hold_v);
                check(in_ready == (!out_valid || out_ready), "R10 ready",
                      {65'b0, in_ready}, {65'b0, (!out_valid || out_ready)});
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R9 unexpected output", {out_attr, out_addr}, '0);
                    end else begin
                        logic [65:0] e;
                        string       t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_attr, out_addr} == e, t, {out_attr, out_addr}, e);
                    end
                end
                hold_p = out_valid && !out_ready;
                hold_v = {out_attr, out_addr};
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_at[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", {65'b0, out_valid}, '0);
        check(in_ready == 1'b1, "R1 in_ready", {65'b0, in_ready}, 66'd1);
        for (int i = 0; i < NE; i++) begin
            cfg_check(i, 0, "R1 low word");
            cfg_check(i, 1, "R1 high word");
        end

        // R7: program table, low bits of low word partly discarded
        for (int i = 0; i < NE; i++) begin
            logic [31:0] v;
            v = 32'h9E37_79B9 * (i + 1);
            v = (v & ~32'h3) | i[1:0];
            cfg_write(i, 0, v);
            cfg_write(i, 1, 32'hC0DE_0000 + i);
        end
        for (int i = 0; i < NE; i++) begin
            cfg_check(i, 0, "R7 low readback");
            cfg_check(i, 1, "R7 high readback");
        end

        // R2 R3 R4 R5: every entry, offsets zero, all ones, mixed with upper local bits
        for (int i = 0; i < NE; i++) begin
            logic [63:0] b;
            b = 64'(i) << PB;
            send(b, 1'b0, "R3 offset zero");
            send(b | LOWM, 1'b0, "R2 offset ones");
            send(b | 64'h0000_0000_FFFF_0000 | 64'h5A5, 1'b0, "R4 R5 mixed, upper local bits");
        end

        // R6: wide mode bypass
        send(64'hDEAD_BEEF_0123_4567, 1'b1, "R6 wide");
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 wide ones");
        send(64'h0000_0001_0000_3ABC, 1'b1, "R6 wide small");

        // R9 R10: backpressure
        rdy_mode = 1'b1;
        for (int k = 0; k < 40; k++)
            send((64'(k) * 64'h0000_0000_0001_3579) ^ 64'h0000_0000_0000_0A5A, k[2], "R9 backpressure");
        rdy_mode = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);

        // R8: write and request on the same edge sees old entry
        @(negedge clk);
        exp_q.push_back(model(64'h0000_5123, 1'b0));
        tag_q.push_back("R8 same-edge old");
        in_valid = 1'b1; in_addr = 64'h0000_5123; wide_mode = 1'b0;
        cfg_wr = 1'b1; cfg_sel = {4'd5, 1'b0}; cfg_wdata = 32'h7777_7001;
        @(negedge clk);
        in_valid = 1'b0; cfg_wr = 1'b0;
        m_lo[5] = 32'h7777_7000; m_at[5] = 2'b01;
        send(64'h0000_5123, 1'b0, "R8 next cycle new");
        cfg_write(5, 0, 32'h2222_2FFE);
        send(64'h0000_5FFF, 1'b0, "R4 upper zeroed after attr clear");

        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule